// File: doc/BRIEF.md
# Control Bit Set/Clear Unit

This unit executes the mask-style Set and Clear I/O instructions of a script-driven bus controller. One instruction word names any subset of four unrelated state bits: the arithmetic carry flag, the target-role bit, and the latched ACK and ATN bus control bits. A Set instruction raises every named bit. A Clear instruction lowers every named bit. Bits that the word does not name keep their value.

The unit also checks the select-with-ATN flag. This flag is legal only on a Select instruction issued in initiator role, where it raises the latched ATN bit for the selection phase. On any other I/O instruction the flag causes an illegal-instruction interrupt pulse, and the instruction then has no effect. The two bus control bits are driven onto the bus only while the device is an initiator or while loopback is enabled. The latched copies still follow every Set and Clear.

The sequencer presents one decoded instruction per cycle with a valid strobe. The role held in the unit serves as the current role for both decoding and bus gating.

Top module: `ctl_bit_unit`

## Requirements
- R1: When `instr_vld` is high, `io_op` = 3 (Set) and bit 24 is clear, each of word bits 10 (carry), 9 (target role), 6 (ACK) and 3 (ATN) that is 1 drives its state bit to 1. State bits whose word bit is 0 are unchanged.
- R2: When `instr_vld` is high, `io_op` = 4 (Clear) and bit 24 is clear, each selected state bit (same positions as R1) becomes 0 and the others are unchanged. Clearing bit 9 returns the device to initiator role.
- R3: Nothing changes the state bits in these cases: `instr_vld` low; `io_op` of 5, 6 or 7; reserved word bits 23-20, 15-11, 8-7, 5-4 and 2-0. `illegal_irq` also stays low in these cases.
- R4: `ack_drive` equals `ack_q` and `atn_drive` equals `atn_q` when `target_q` is 0 or `loopback_en` is 1. Otherwise both drives are 0.
- R5: Bit 24 set on an I/O opcode (0 to 4) is illegal, except on `io_op` = 0 with `target_q` = 0 (Select). An illegal instruction pulses `illegal_irq` and leaves all four state bits unchanged.
- R6: `io_op` = 0 with bit 24 set while `target_q` = 0 sets `atn_q` and raises no interrupt.
- R7: State changes and `illegal_irq` appear on the clock edge that samples the strobe. `illegal_irq` is high for exactly one cycle per illegal instruction.
- R8: While `rst_n` is low, all four state bits, both drives and `illegal_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_vld | input | 1 | Instruction valid strobe, one cycle per instruction |
| io_op | input | 3 | Decoded I/O opcode (0 Select/Reselect, 1 Disconnect, 2 Wait, 3 Set, 4 Clear) |
| instr_word | input | 32 | First instruction dword |
| loopback_en | input | 1 | Loopback mode, allows bus drive in target role |
| carry_q | output | 1 | Carry flag |
| target_q | output | 1 | Role bit, 1 = target |
| ack_q | output | 1 | Latched ACK control bit |
| atn_q | output | 1 | Latched ATN control bit |
| ack_drive | output | 1 | ACK bus drive enable |
| atn_drive | output | 1 | ATN bus drive enable |
| illegal_irq | output | 1 | Illegal-instruction interrupt pulse |

## Verification
The assertions assume three things about the inputs. Each instruction word is sampled only in the cycle where its strobe is high. `io_op` is already decoded, so the unit does not judge the upper opcode bits of the word. `loopback_en` changes only between instructions. The stimulus changes every input at the falling edge. It keeps loopback fixed whenever an instruction is in flight, and it includes back-to-back strobes, so that each illegal instruction produces its own pulse. The stimulus also exercises both roles, so that the meaning of opcode 0 flips between Select and Reselect.

// File: rtl/ctl_bit_pkg.sv
package ctl_bit_pkg;
  localparam int WORD_W   = 32;
  localparam int N_BITS   = 4;
  localparam int N_DRV    = 2;
  // word bit positions decoded by the unit
  localparam int POS_CRY  = 10;
  localparam int POS_TGT  = 9;
  localparam int POS_ACK  = 6;
  localparam int POS_ATN  = 3;
  localparam int POS_SATN = 24;
  // indices into the packed state vector
  localparam int IX_ATN   = 0;
  localparam int IX_ACK   = 1;
  localparam int IX_TGT   = 2;
  localparam int IX_CRY   = 3;
  localparam int OP_W     = 3;

  typedef enum logic [OP_W-1:0] {
    OP_SEL  = 3'd0,
    OP_DISC = 3'd1,
    OP_WAIT = 3'd2,
    OP_SET  = 3'd3,
    OP_CLR  = 3'd4
  } io_op_e;

  function automatic logic [N_BITS-1:0] f_mask(input logic [WORD_W-1:0] w);
    logic [N_BITS-1:0] m;
    m = '0;
    m[IX_CRY] = w[POS_CRY];
    m[IX_TGT] = w[POS_TGT];
    m[IX_ACK] = w[POS_ACK];
    m[IX_ATN] = w[POS_ATN];
    return m;
  endfunction

  function automatic logic f_is_io(input logic [OP_W-1:0] op);
    return op <= OP_CLR;
  endfunction

  function automatic logic f_illegal(input logic [OP_W-1:0] op, input logic satn,
                                     input logic tgt);
    return f_is_io(op) && satn && !(op == OP_SEL && !tgt);
  endfunction

  function automatic logic [N_BITS-1:0] f_apply(input logic [N_BITS-1:0] cur,
                                                input logic [N_BITS-1:0] m,
                                                input logic set_not_clr);
    return set_not_clr ? (cur | m) : (cur & ~m);
  endfunction
endpackage

// File: rtl/ctl_bit_decode.sv
module ctl_bit_decode
  import ctl_bit_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic              vld,
  input  logic [OP_W-1:0]   op,
  input  logic [W-1:0]      word,
  input  logic [N_BITS-1:0] cur,
  output logic              illegal_ev,
  output logic              sel_atn_ev,
  output logic              upd_en,
  output logic [N_BITS-1:0] nxt
);
  logic setclr_ev;
  logic unused_word;

  // reserved and type bits are not decoded here
  assign unused_word = ^{word[W-1:POS_SATN+1], word[POS_SATN-1:POS_CRY+1],
                         word[POS_TGT-1:POS_ACK+1], word[POS_ACK-1:POS_ATN+1],
                         word[POS_ATN-1:0]};

  always_comb begin
    illegal_ev = vld && f_illegal(op, word[POS_SATN], cur[IX_TGT]);
    sel_atn_ev = vld && (op == OP_SEL) && !cur[IX_TGT] && word[POS_SATN];
    setclr_ev  = vld && !illegal_ev && ((op == OP_SET) || (op == OP_CLR));
    upd_en     = setclr_ev || sel_atn_ev;
    if (sel_atn_ev) begin
      nxt = cur;
      nxt[IX_ATN] = 1'b1;
    end else begin
      nxt = f_apply(cur, f_mask(word), op == OP_SET);
    end
  end
endmodule

// File: rtl/ctl_bit_regs.sv
module ctl_bit_regs
  import ctl_bit_pkg::*;
#(
  parameter int N = N_BITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_en,
  input  logic [N-1:0] nxt,
  input  logic         illegal_ev,
  output logic [N-1:0] state_q,
  output logic         irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= illegal_ev;
      if (upd_en) state_q <= nxt;
    end
  end
endmodule

// File: rtl/ctl_bit_drive.sv
module ctl_bit_drive #(
  parameter int NDRV = 2
) (
  input  logic [NDRV-1:0] latched,
  input  logic            tgt,
  input  logic            loopback,
  output logic [NDRV-1:0] drv
);
  logic allow;
  assign allow = !tgt || loopback;

  for (genvar g = 0; g < NDRV; g++) begin : g_drv
    assign drv[g] = latched[g] && allow;
  end
endmodule

// File: rtl/ctl_bit_unit.sv
module ctl_bit_unit
  import ctl_bit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_vld,
  input  logic [2:0]        io_op,
  input  logic [31:0]       instr_word,
  input  logic              loopback_en,
  output logic              carry_q,
  output logic              target_q,
  output logic              ack_q,
  output logic              atn_q,
  output logic              ack_drive,
  output logic              atn_drive,
  output logic              illegal_irq
);
  logic [N_BITS-1:0] state_q;
  logic [N_BITS-1:0] nxt;
  logic              upd_en;
  logic              illegal_ev;
  logic              sel_atn_ev;
  logic [N_DRV-1:0]  drv;

  ctl_bit_decode #(.W(WORD_W)) u_dec (
    .vld        (instr_vld),
    .op         (io_op),
    .word       (instr_word),
    .cur        (state_q),
    .illegal_ev (illegal_ev),
    .sel_atn_ev (sel_atn_ev),
    .upd_en     (upd_en),
    .nxt        (nxt)
  );

  ctl_bit_regs #(.N(N_BITS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_en     (upd_en),
    .nxt        (nxt),
    .illegal_ev (illegal_ev),
    .state_q    (state_q),
    .irq_q      (illegal_irq)
  );

  ctl_bit_drive #(.NDRV(N_DRV)) u_drv (
    .latched  ({state_q[IX_ACK], state_q[IX_ATN]}),
    .tgt      (state_q[IX_TGT]),
    .loopback (loopback_en),
    .drv      (drv)
  );

  assign carry_q   = state_q[IX_CRY];
  assign target_q  = state_q[IX_TGT];
  assign ack_q     = state_q[IX_ACK];
  assign atn_q     = state_q[IX_ATN];
  assign ack_drive = drv[1];
  assign atn_drive = drv[0];
endmodule

// File: rtl/ctl_bit_chk.sv
module ctl_bit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        instr_vld,
  input logic [2:0]  io_op,
  input logic [31:0] instr_word,
  input logic        loopback_en,
  input logic        carry_q,
  input logic        target_q,
  input logic        ack_q,
  input logic        atn_q,
  input logic        ack_drive,
  input logic        atn_drive,
  input logic        illegal_irq,
  input logic        illegal_ev,
  input logic        sel_atn_ev
);
  logic [3:0] bits;
  assign bits = {carry_q, target_q, ack_q, atn_q};

  a_r1_set_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_vld && io_op == 3'd3 && !instr_word[24] && instr_word[10]) |=> carry_q);

  a_r2_clear_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_vld && io_op == 3'd4 && !instr_word[24] && instr_word[6]) |=> !ack_q);

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_vld |=> ($stable(bits) && !illegal_irq));

  a_r4_drive_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (target_q && !loopback_en) |-> (!ack_drive && !atn_drive));

  a_r5_illegal_hold: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_ev |=> (illegal_irq && $stable(bits)));

  a_r6_select_atn: assert property (@(posedge clk) disable iff (!rst_n)
    sel_atn_ev |=> (atn_q && !illegal_irq));

  a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_irq |-> $past(illegal_ev));
endmodule

bind ctl_bit_unit ctl_bit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_vld   (instr_vld),
  .io_op       (io_op),
  .instr_word  (instr_word),
  .loopback_en (loopback_en),
  .carry_q     (carry_q),
  .target_q    (target_q),
  .ack_q       (ack_q),
  .atn_q       (atn_q),
  .ack_drive   (ack_drive),
  .atn_drive   (atn_drive),
  .illegal_irq (illegal_irq),
  .illegal_ev  (illegal_ev),
  .sel_atn_ev  (sel_atn_ev)
);

// File: tb/test_ctl_bit_unit.sv
`timescale 1ns/1ps
module test_ctl_bit_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_vld = 1'b0;
  logic [2:0]  io_op = 3'd0;
  logic [31:0] instr_word = 32'd0;
  logic        loopback_en = 1'b0;
  logic        carry_q, target_q, ack_q, atn_q, ack_drive, atn_drive, illegal_irq;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic [6:0] v;   // cry,tgt,ack,atn,ackdrv,atndrv,irq
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  // bench reference state
  logic m_cry = 0, m_tgt = 0, m_ack = 0, m_atn = 0;

  always #2.5 clk = ~clk;

  ctl_bit_unit i_ctl_bit_unit (
    .clk(clk), .rst_n(rst_n), .instr_vld(instr_vld), .io_op(io_op),
    .instr_word(instr_word), .loopback_en(loopback_en), .carry_q(carry_q),
    .target_q(target_q), .ack_q(ack_q), .atn_q(atn_q), .ack_drive(ack_drive),
    .atn_drive(atn_drive), .illegal_irq(illegal_irq)
  );

  function automatic logic [6:0] observed();
    return {carry_q, target_q, ack_q, atn_q, ack_drive, atn_drive, illegal_irq};
  endfunction

  task automatic compare(input logic [6:0] act, input logic [6:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b (cry,tgt,ack,atn,ackdrv,atndrv,irq)",
               tag, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and predicts the result
  task automatic issue(input logic vld, input logic [2:0] op, input logic [31:0] w,
                       input logic lb, input string tag);
    logic bad;
    logic gate;
    exp_t e;
    @(negedge clk);
    instr_vld   = vld;
    io_op       = op;
    instr_word  = w;
    loopback_en = lb;
    bad = 1'b0;
    if (vld && w[24]) begin
      if (op == 3'd0 && !m_tgt) m_atn = 1'b1;
      else if (op < 3'd5)        bad = 1'b1;
    end
    if (vld && !bad && op == 3'd3) begin
      if (w[10]) m_cry = 1'b1;
      if (w[9])  m_tgt = 1'b1;
      if (w[6])  m_ack = 1'b1;
      if (w[3])  m_atn = 1'b1;
    end
    if (vld && !bad && op == 3'd4) begin
      if (w[10]) m_cry = 1'b0;
      if (w[9])  m_tgt = 1'b0;
      if (w[6])  m_ack = 1'b0;
      if (w[3])  m_atn = 1'b0;
    end
    gate  = lb | ~m_tgt;
    e.v   = {m_cry, m_tgt, m_ack, m_atn, m_ack & gate, m_atn & gate, bad};
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: one scoreboard entry per cycle, sampled after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        compare(observed(), e.v, e.tag);
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(observed(), 7'b0, "R8 reset state");
    rst_n = 1'b1;
    issue(1, 3'd3, 32'h0000_0400, 0, "R1 set carry");
    issue(1, 3'd3, 32'h0000_0048, 0, "R1 set ack+atn");
    issue(1, 3'd4, 32'h0000_0008, 0, "R2 clear atn");
    issue(1, 3'd3, 32'h0000_0200, 0, "R4 target role gates drive");
    issue(0, 3'd4, 32'h0000_0648, 1, "R3 no strobe / R4 loopback drive");
    issue(1, 3'd3, 32'h00F0_F9B7, 1, "R3 reserved bits");
    issue(1, 3'd5, 32'h0000_0648, 1, "R3 non-io opcode");
    issue(1, 3'd4, 32'h0100_0400, 0, "R5 clear with bit24");
    issue(1, 3'd0, 32'h0100_0000, 0, "R5 reselect with bit24 (back to back R7)");
    issue(0, 3'd0, 32'h0000_0000, 0, "R7 irq drops");
    issue(1, 3'd4, 32'h0000_0200, 0, "R2 clear target");
    issue(1, 3'd0, 32'h0100_0000, 0, "R6 select with atn");
    issue(1, 3'd2, 32'h0100_0000, 0, "R5 wait with bit24");
    issue(0, 3'd2, 32'h0000_0000, 0, "R7 single pulse");
    issue(1, 3'd4, 32'h0000_0648, 0, "R2 clear all");
    issue(1, 3'd3, 32'h0000_0648, 0, "R1 set all, R4 gated");
    issue(1, 3'd1, 32'h0100_0000, 1, "R5 disconnect with bit24");
    issue(0, 3'd0, 32'h0000_0000, 1, "R4 loopback drive");
    issue(0, 3'd0, 32'h0000_0000, 1, "R7 idle");
    repeat (3) @(negedge clk);
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule